// File: doc/BRIEF.md
# Unpacker command register with stop, break and flush control

This block is the write-only command register in front of a packet-unpacking engine. Software writes one word. The low four bits of that word are command strobes: flush-and-reinitialise, force a break, request a stop, and cancel a stop. One write may carry any mix of these. The block applies them in a fixed order, and a later command overrides an earlier one.

A stop request does not halt the engine at once. The request is kept as a pending flag. It becomes the stop status only when the instruction sequencer signals that it has reached an instruction boundary. A flush command produces a one-cycle flush strobe. With the strobe comes the FIFO read position to restart from, which is the word just after the current program-counter word, so that a stalled instruction is not replayed. The block also combines its status with the interrupt-stall condition into a single hold signal for the sequencer.

Top module: `unpk_cmd_reg`

## Requirements
- R1: A write decodes the data bits as follows: bit 0 is flush, bit 1 is break, bit 2 is stop and bit 3 is cancel. Bits 4 and above have no effect.
- R2: Cancel clears both the stop-status flag and the stop-pending flag on the clock edge of the write.
- R3: Stop sets the stop-pending flag and leaves the stop status unchanged. When stop and cancel arrive in the same write, the pending flag ends up set.
- R4: When the boundary strobe is high and the pending flag is set, outside an interrupt hold, the stop status becomes 1 and the pending flag becomes 0 on that edge.
- R5: Break sets the break-status flag.
- R6: Flush raises flush_o for exactly the cycle after the write, with flush_ptr_o equal to pc_word_i+1 modulo 2^PTR_W. It clears all three status flags and overrides stop and break in the same write.
- R7: hold_o equals stop_stat_o OR brk_stat_o OR (irq_stall_i AND NOT irq_mask_i).
- R8: While irq_stall_i=1 and irq_mask_i=0, the boundary strobe leaves the stop flags unchanged.
- R9: rd_data_o is always zero. A write with bits 3:0 all zero changes no output.
- R10: When a boundary transfer and a write fall on the same edge, the transfer is applied first and the write's commands are applied after it.
- R11: After reset, all status flags, flush_o and flush_ptr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, always zero |
| insn_boundary_i | input | 1 | Sequencer is at an instruction boundary |
| pc_word_i | input | PTR_W | Current program-counter FIFO word index |
| irq_stall_i | input | 1 | Interrupt-stall status |
| irq_mask_i | input | 1 | Interrupt-stall mask from the error register |
| stop_pend_o | output | 1 | Stop requested, waiting for a boundary |
| stop_stat_o | output | 1 | Stopped |
| brk_stat_o | output | 1 | Force-break status |
| flush_o | output | 1 | One-cycle FIFO flush request |
| flush_ptr_o | output | PTR_W | FIFO read position to restart from |
| hold_o | output | 1 | Sequencer must hold and retry |

## Verification
The bench first runs single-command writes. These isolate each bit's effect. It then runs paired commands (stop with cancel, break with flush, stop with flush), which show whether the override order is right or reversed. Boundary strobes are placed alone, under an unmasked interrupt stall, under a masked stall, and on the same edge as a write. These placements separate a correct pending-to-status transfer from one that is premature, blocked, or ordered wrongly against the write. A long run of random writes with upper-bit noise, compared every cycle against a behavioural model, catches decode shifts and a flush pointer that wraps wrongly.

// File: rtl/unpk_cmd_pkg.sv
package unpk_cmd_pkg;
  localparam int NCMD       = 4;
  localparam int CMD_FLUSH  = 0;
  localparam int CMD_BRK    = 1;
  localparam int CMD_STOP   = 2;
  localparam int CMD_CANCEL = 3;

  // field order matches bit positions (MSB first)
  typedef struct packed {
    logic cancel;
    logic stop;
    logic brk;
    logic flush;
  } cmd_t;
endpackage

// File: rtl/unpk_cmd_decode.sv
module unpk_cmd_decode
  import unpk_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cmd_t              cmd_o
);
  logic [NCMD-1:0] cmd_v;
  logic            unused_data;

  for (genvar i = 0; i < NCMD; i++) begin : g_bit
    assign cmd_v[i] = wr_en_i & wr_data_i[i];
  end

  assign cmd_o       = cmd_t'(cmd_v);
  assign unused_data = ^wr_data_i[DATA_W-1:NCMD];
endmodule

// File: rtl/unpk_cmd_flags.sv
module unpk_cmd_flags
  import unpk_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_t cmd_i,
  input  logic boundary_i,
  input  logic irq_hold_i,
  output logic stop_pend_o,
  output logic stop_stat_o,
  output logic brk_stat_o
);
  logic pend_d, stat_d, brk_d;

  // boundary transfer first, then commands least to most overriding
  always_comb begin
    pend_d = stop_pend_o;
    stat_d = stop_stat_o;
    brk_d  = brk_stat_o;
    if (boundary_i && stop_pend_o && !irq_hold_i) begin
      stat_d = 1'b1;
      pend_d = 1'b0;
    end
    if (cmd_i.cancel) begin
      stat_d = 1'b0;
      pend_d = 1'b0;
    end
    if (cmd_i.stop) pend_d = 1'b1;
    if (cmd_i.brk)  brk_d  = 1'b1;
    if (cmd_i.flush) begin
      pend_d = 1'b0;
      stat_d = 1'b0;
      brk_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_pend_o <= 1'b0;
      stop_stat_o <= 1'b0;
      brk_stat_o  <= 1'b0;
    end else begin
      stop_pend_o <= pend_d;
      stop_stat_o <= stat_d;
      brk_stat_o  <= brk_d;
    end
  end
endmodule

// File: rtl/unpk_cmd_flush.sv
module unpk_cmd_flush #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [PTR_W-1:0] pc_word_i,
  output logic             flush_o,
  output logic [PTR_W-1:0] flush_ptr_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_o     <= 1'b0;
      flush_ptr_o <= '0;
    end else begin
      flush_o <= req_i;
      if (req_i) flush_ptr_o <= pc_word_i + ONE;
    end
  end
endmodule

// File: rtl/unpk_cmd_reg.sv
module unpk_cmd_reg
  import unpk_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              insn_boundary_i,
  input  logic [PTR_W-1:0]  pc_word_i,
  input  logic              irq_stall_i,
  input  logic              irq_mask_i,
  output logic              stop_pend_o,
  output logic              stop_stat_o,
  output logic              brk_stat_o,
  output logic              flush_o,
  output logic [PTR_W-1:0]  flush_ptr_o,
  output logic              hold_o
);
  cmd_t cmd;
  logic irq_hold;

  assign irq_hold  = irq_stall_i & ~irq_mask_i;
  assign rd_data_o = '0;

  unpk_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd)
  );

  unpk_cmd_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .boundary_i  (insn_boundary_i),
    .irq_hold_i  (irq_hold),
    .stop_pend_o (stop_pend_o),
    .stop_stat_o (stop_stat_o),
    .brk_stat_o  (brk_stat_o)
  );

  unpk_cmd_flush #(.PTR_W(PTR_W)) u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cmd.flush),
    .pc_word_i   (pc_word_i),
    .flush_o     (flush_o),
    .flush_ptr_o (flush_ptr_o)
  );

  assign hold_o = stop_stat_o | brk_stat_o | irq_hold;
endmodule

// File: rtl/unpk_cmd_reg_chk.sv
module unpk_cmd_reg_chk #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              insn_boundary_i,
  input logic [PTR_W-1:0]  pc_word_i,
  input logic              irq_stall_i,
  input logic              irq_mask_i,
  input logic              stop_pend_o,
  input logic              stop_stat_o,
  input logic              brk_stat_o,
  input logic              flush_o,
  input logic [PTR_W-1:0]  flush_ptr_o,
  input logic              hold_o
);
  assert_cancel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[3] && !wr_data_i[2] && !wr_data_i[0]
    |=> !stop_pend_o && !stop_stat_o);

  assert_stop_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[2] && !wr_data_i[0] |=> stop_pend_o);

  assert_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_boundary_i && stop_pend_o && !(irq_stall_i && !irq_mask_i) && !wr_en_i
    |=> stop_stat_o && !stop_pend_o);

  assert_brk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[1] && !wr_data_i[0] |=> brk_stat_o);

  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[0]
    |=> flush_o && !stop_pend_o && !stop_stat_o && !brk_stat_o
        && flush_ptr_o == $past(pc_word_i) + PTR_W'(1));

  assert_flush_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_data_i[0]) |=> !flush_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stall_i && !irq_mask_i) || stop_stat_o || brk_stat_o |-> hold_o);

  assert_irq_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_stall_i && !irq_mask_i && !wr_en_i
    |=> $stable(stop_pend_o) && $stable(stop_stat_o));

  assert_noop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[3:0] == 4'b0 && !insn_boundary_i
    |=> $stable(stop_pend_o) && $stable(stop_stat_o) && $stable(brk_stat_o) && !flush_o);
endmodule

bind unpk_cmd_reg unpk_cmd_reg_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/unpk_cmd_reg_test.sv
module unpk_cmd_reg_test;
  localparam int DATA_W = 32;
  localparam int PTR_W  = 8;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              wr_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              bnd = 0;
  logic [PTR_W-1:0]  pc = '0;
  logic              irq_stall = 0;
  logic              irq_mask = 0;
  logic              stop_pend, stop_stat, brk_stat, flush, hold;
  logic [PTR_W-1:0]  flush_ptr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  string cur_req = "R11";

  // reference state
  bit m_pend, m_stat, m_brk, m_flush;
  int m_ptr;

  always #2.5 clk = ~clk;

  unpk_cmd_reg #(.DATA_W(DATA_W), .PTR_W(PTR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .insn_boundary_i(bnd), .pc_word_i(pc),
    .irq_stall_i(irq_stall), .irq_mask_i(irq_mask),
    .stop_pend_o(stop_pend), .stop_stat_o(stop_stat), .brk_stat_o(brk_stat),
    .flush_o(flush), .flush_ptr_o(flush_ptr), .hold_o(hold)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_stat = 0; m_brk = 0; m_flush = 0; m_ptr = 0;
    end else begin
      bit ih;
      ih = irq_stall && !irq_mask;
      if (bnd && m_pend && !ih) begin m_stat = 1; m_pend = 0; end
      m_flush = 0;
      if (wr_en) begin
        if (wr_data[3]) begin m_stat = 0; m_pend = 0; end
        if (wr_data[2]) m_pend = 1;
        if (wr_data[1]) m_brk = 1;
        if (wr_data[0]) begin
          m_pend = 0; m_stat = 0; m_brk = 0; m_flush = 1;
          m_ptr = (int'(pc) + 1) % (1 << PTR_W);
        end
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_req, "stop_pend", stop_pend, m_pend);
    chk(cur_req, "stop_stat", stop_stat, m_stat);
    chk(cur_req, "brk_stat", brk_stat, m_brk);
    chk(cur_req, "flush", flush, m_flush);
    chk(cur_req, "flush_ptr", flush_ptr, m_ptr);
    chk("R7", "hold", hold, m_stat | m_brk | (irq_stall & ~irq_mask));
    chk("R9", "rd_data", rd_data, 0);
  endtask

  // drive inputs at negedge, check 1 ns after the following posedge
  task automatic cyc(string req, bit w, logic [DATA_W-1:0] d, bit b,
                     logic [PTR_W-1:0] p, bit is, bit im);
    cur_req = req;
    wr_en = w; wr_data = d; bnd = b; pc = p; irq_stall = is; irq_mask = im;
    @(posedge clk); #1;
    compare();
    @(negedge clk);
  endtask

  task automatic idle(string req);
    cyc(req, 0, '0, 0, pc, irq_stall, irq_mask);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "stop_pend", stop_pend, 0);
    chk("R11", "stop_stat", stop_stat, 0);
    chk("R11", "brk_stat", brk_stat, 0);
    chk("R11", "flush", flush, 0);
    chk("R11", "flush_ptr", flush_ptr, 0);
    rst_n = 1;
    @(negedge clk);

    cyc("R3", 1, 32'h4, 0, 8'h10, 0, 0);      // stop alone: pending only
    chk("R3", "stop_stat stays", stop_stat, 0);
    idle("R3");
    cyc("R4", 0, '0, 1, 8'h10, 0, 0);         // boundary transfer
    chk("R4", "stop_stat", stop_stat, 1);
    chk("R7", "hold on stop", hold, 1);
    cyc("R2", 1, 32'h8, 0, 8'h10, 0, 0);      // cancel
    chk("R2", "stop_stat cleared", stop_stat, 0);
    cyc("R3", 1, 32'hC, 0, 8'h10, 0, 0);      // stop+cancel -> pending
    chk("R3", "stop beats cancel", stop_pend, 1);
    cyc("R8", 0, '0, 1, 8'h10, 1, 0);         // boundary under irq hold
    chk("R8", "pending kept", stop_pend, 1);
    chk("R7", "hold irq", hold, 1);
    cyc("R4", 0, '0, 1, 8'h10, 1, 1);         // masked irq: transfer
    chk("R4", "stop_stat masked", stop_stat, 1);
    cyc("R2", 1, 32'h8, 0, 8'h10, 0, 0);
    cyc("R5", 1, 32'h2, 0, 8'h10, 0, 0);      // break
    chk("R5", "brk_stat", brk_stat, 1);
    cyc("R6", 1, 32'h3, 0, 8'h12, 0, 0);      // break+flush
    chk("R6", "flush", flush, 1);
    chk("R6", "flush_ptr", flush_ptr, 8'h13);
    chk("R6", "brk cleared", brk_stat, 0);
    idle("R6");
    chk("R6", "flush one cycle", flush, 0);
    cyc("R6", 1, 32'h1, 0, 8'hFF, 0, 0);      // wrap
    chk("R6", "flush_ptr wrap", flush_ptr, 0);
    cyc("R6", 1, 32'h5, 0, 8'h20, 0, 0);      // stop+flush
    chk("R6", "flush beats stop", stop_pend, 0);
    cyc("R5", 1, 32'h2, 0, 8'h20, 0, 0);
    cyc("R9", 1, 32'hFFFF_FFF0, 0, 8'h20, 0, 0); // no command bits
    chk("R9", "noop brk kept", brk_stat, 1);
    chk("R1", "upper bits no flush", flush, 0);
    cyc("R6", 1, 32'h1, 0, 8'h20, 0, 0);
    cyc("R10", 1, 32'h4, 1, 8'h20, 0, 0);     // stop + boundary, pend was 0
    chk("R10", "no early stat", stop_stat, 0);
    cyc("R10", 1, 32'h8, 1, 8'h20, 0, 0);     // cancel + boundary
    chk("R10", "cancel after transfer", stop_stat, 0);
    chk("R10", "pend cleared", stop_pend, 0);

    for (int i = 0; i < 400; i++) begin
      logic [DATA_W-1:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[0] = 1'b0;
      cyc("R1", $urandom_range(0, 2) == 0, d, $urandom_range(0, 1) == 1,
          PTR_W'($urandom), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule